// File: doc/BRIEF.md
# I2C Slave Address Acknowledge Unit

This unit sits beside the shift register of a two-wire serial bus controller and decides, once per received byte, whether the controller pulls SDA low during the acknowledge clock. It compares the address byte that follows a START with a programmable 7-bit own address. It can also accept the all-zero general-call address. It acknowledges data bytes according to the current receive mode. It remembers whether the device was selected within the current transfer.

A software acknowledge enable logically detaches the device: with it low, nothing is acknowledged and the address is not recognised. Setting it high again resumes address recognition at the next address byte. A recovery strobe, honoured only in slave modes, returns the unit to an unaddressed, released state without putting a STOP on the bus. The interface enable aborts everything immediately.

The START/STOP detector, the SCL edge detector and the bit shifter are outside the unit and feed it single-cycle strobes. The first `byte_done` after a `start_det` is the address byte. Every later `byte_done` is a data byte.

Top module: `i2cack_top`

## Requirements
- R1: An address byte whose bits [7:1] equal `own_addr` produces `sda_low`=1 and `addressed`=1 in the cycle after `byte_done`, whatever bit 0 (direction) holds, provided `ack_en`=1 and mode is not master receiver.
- R2: An address byte with bits [7:1] all zero is acknowledged and sets `addressed` only when `gc_en`=1; with `gc_en`=0 neither output rises.
- R3: A data byte is acknowledged in master receiver mode (`mode`=2'b01) always, and in slave receiver mode (`mode`=2'b10) only while `addressed`=1.
- R4: With `ack_en`=0 no byte is acknowledged and no address byte sets `addressed`; once `ack_en` returns to 1, the next matching address byte is acknowledged again.
- R5: `sda_low` clears on the first `scl_fall` after the cycle that set it; a `byte_done` in the same cycle as `scl_fall` takes precedence and sets it.
- R6: `recover` in any mode other than master receiver clears `sda_low` and `addressed` in the next cycle; in master receiver mode it has no effect.
- R7: While `enable`=0 both outputs are 0 and received bytes are ignored; synchronous `rst` also clears both.
- R8: `stop_det` clears `addressed`; after a repeated START, `addressed` holds until the address byte, then follows that byte's match result.
- R9: An address byte in master receiver mode is never acknowledged, and data bytes in idle (2'b00) or unaddressed (2'b11) mode are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Interface enable; low aborts all activity |
| ack_en | input | 1 | Software acknowledge enable |
| gc_en | input | 1 | Accept the general-call address |
| own_addr | input | 7 | Own slave address |
| mode | input | 2 | 00 idle, 01 master receiver, 10 slave receiver, 11 unaddressed |
| start_det | input | 1 | START or repeated START seen (strobe) |
| stop_det | input | 1 | STOP seen (strobe) |
| byte_done | input | 1 | Eighth bit shifted in, at its SCL falling edge (strobe) |
| rx_byte | input | 8 | Received byte, valid with byte_done |
| scl_fall | input | 1 | SCL falling edge (strobe) |
| recover | input | 1 | Slave-side error recovery request (strobe) |
| sda_low | output | 1 | Pull SDA low for acknowledge |
| addressed | output | 1 | Device selected in the current transfer |

## Verification
A wrong pending-address flag shows up at the first `byte_done` after it goes wrong. A stale flag makes a data byte look like an address byte, or the reverse. Either way `sda_low` is wrong one cycle later, during the ninth clock of that byte. A stuck `addressed` register changes how slave-receiver data is acknowledged on the very next byte. It is also visible directly on the port in the cycle after a STOP, recovery or disable. The bench therefore samples both outputs after every single strobe.

// File: rtl/i2cack_pkg.sv
package i2cack_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE   = 2'b00,
    MODE_MRX    = 2'b01,
    MODE_SRX    = 2'b10,
    MODE_UNADDR = 2'b11
  } mode_e;

  function automatic logic is_slave_side(input logic [1:0] m);
    return m != MODE_MRX;
  endfunction
endpackage

// File: rtl/i2cack_match.sv
module i2cack_match #(
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W-1:0] addr_field,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              gc_en,
  output logic              hit
);
  logic own_hit;
  logic gc_hit;

  assign own_hit = (addr_field == own_addr);
  assign gc_hit  = gc_en && (addr_field == '0);
  assign hit     = own_hit || gc_hit;
endmodule

// File: rtl/i2cack_track.sv
module i2cack_track (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic abort_slave,
  input  logic start_det,
  input  logic stop_det,
  input  logic byte_done,
  input  logic slave_side,
  input  logic addr_hit,
  output logic addr_pending,
  output logic addressed
);
  always_ff @(posedge clk) begin
    if (rst || !enable || abort_slave || stop_det) begin
      addr_pending <= 1'b0;
      addressed    <= 1'b0;
    end else if (start_det) begin
      addr_pending <= 1'b1;
    end else if (byte_done) begin
      addr_pending <= 1'b0;
      if (addr_pending && slave_side)
        addressed <= addr_hit;
    end
  end
endmodule

// File: rtl/i2cack_drive.sv
module i2cack_drive (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic abort_slave,
  input  logic stop_det,
  input  logic byte_done,
  input  logic scl_fall,
  input  logic ack_now,
  output logic sda_low
);
  always_ff @(posedge clk) begin
    if (rst || !enable || abort_slave || stop_det)
      sda_low <= 1'b0;
    else if (byte_done)
      sda_low <= ack_now;
    else if (scl_fall)
      sda_low <= 1'b0;
  end
endmodule

// File: rtl/i2cack_top.sv
module i2cack_top
  import i2cack_pkg::*;
#(
  parameter int ADDR_W = 7,
  localparam int BYTE_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              ack_en,
  input  logic              gc_en,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [1:0]        mode,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              scl_fall,
  input  logic              recover,
  output logic              sda_low,
  output logic              addressed
);
  logic match_hit;
  logic addr_hit;
  logic addr_pending;
  logic slave_side;
  logic abort_slave;
  logic data_ack;
  logic ack_now;

  assign slave_side  = is_slave_side(mode);
  assign abort_slave = recover && slave_side;

  i2cack_match #(.ADDR_W(ADDR_W)) u_match (
    .addr_field (rx_byte[BYTE_W-1:1]),
    .own_addr   (own_addr),
    .gc_en      (gc_en),
    .hit        (match_hit)
  );

  assign addr_hit = ack_en && match_hit;
  assign data_ack = (mode == MODE_MRX) || ((mode == MODE_SRX) && addressed);
  assign ack_now  = ack_en && (addr_pending ? (slave_side && match_hit) : data_ack);

  i2cack_track u_track (
    .clk          (clk),
    .rst          (rst),
    .enable       (enable),
    .abort_slave  (abort_slave),
    .start_det    (start_det),
    .stop_det     (stop_det),
    .byte_done    (byte_done),
    .slave_side   (slave_side),
    .addr_hit     (addr_hit),
    .addr_pending (addr_pending),
    .addressed    (addressed)
  );

  i2cack_drive u_drive (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .abort_slave (abort_slave),
    .stop_det    (stop_det),
    .byte_done   (byte_done),
    .scl_fall    (scl_fall),
    .ack_now     (ack_now),
    .sda_low     (sda_low)
  );
endmodule

// File: rtl/i2cack_checker.sv
module i2cack_checker #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              enable,
  input logic              ack_en,
  input logic              gc_en,
  input logic [ADDR_W-1:0] own_addr,
  input logic [1:0]        mode,
  input logic              stop_det,
  input logic              byte_done,
  input logic [ADDR_W:0]   rx_byte,
  input logic              scl_fall,
  input logic              recover,
  input logic              sda_low,
  input logic              addressed
);
  // R1 / R2: selection only follows a byte that matched own or general-call address
  p_select_source_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(addressed) |-> ($past(byte_done) &&
      ((($past(rx_byte) >> 1) == {1'b0, $past(own_addr)}) ||
       ((($past(rx_byte) >> 1) == '0) && $past(gc_en)))));

  p_no_ack_when_off_r4: assert property (@(posedge clk) disable iff (rst)
    (byte_done && !ack_en) |=> !$rose(sda_low));

  p_release_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
    (sda_low && scl_fall && !byte_done) |=> !sda_low);

  p_recover_slave_r6: assert property (@(posedge clk) disable iff (rst)
    (enable && recover && mode != 2'b01) |=> (!sda_low && !addressed));

  p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!sda_low && !addressed));

  p_stop_unselects_r8: assert property (@(posedge clk) disable iff (rst)
    (enable && stop_det) |=> !addressed);

  p_master_no_select_r9: assert property (@(posedge clk) disable iff (rst)
    (byte_done && mode == 2'b01) |=> !$rose(addressed));
endmodule

bind i2cack_top i2cack_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .enable    (enable),
  .ack_en    (ack_en),
  .gc_en     (gc_en),
  .own_addr  (own_addr),
  .mode      (mode),
  .stop_det  (stop_det),
  .byte_done (byte_done),
  .rx_byte   (rx_byte),
  .scl_fall  (scl_fall),
  .recover   (recover),
  .sda_low   (sda_low),
  .addressed (addressed)
);

// File: tb/i2cack_top_test.sv
module i2cack_top_test;
  typedef struct packed {
    logic       st;
    logic       sp;
    logic       bd;
    logic       fl;
    logic       rc;
    logic [1:0] md;
    logic       ae;
    logic       ge;
    logic [7:0] b;
    logic       es;
    logic       ea;
    logic [3:0] rq;
  } vec_t;

  function automatic vec_t mk(input logic st, input logic sp, input logic bd,
                              input logic fl, input logic rc, input logic [1:0] md,
                              input logic ae, input logic ge, input logic [7:0] b,
                              input logic es, input logic ea, input logic [3:0] rq);
    vec_t v;
    v.st = st; v.sp = sp; v.bd = bd; v.fl = fl; v.rc = rc; v.md = md;
    v.ae = ae; v.ge = ge; v.b = b; v.es = es; v.ea = ea; v.rq = rq;
    return v;
  endfunction

  localparam logic [1:0] IDL = 2'b00, MRX = 2'b01, SRX = 2'b10, UNA = 2'b11;
  localparam int NV = 35;
  // own address 0x2A: address bytes 0x54 (write) / 0x55 (read)
  // fields: start stop byte_done scl_fall recover mode ack_en gc_en byte | exp sda exp addr | req
  localparam vec_t VECS [NV] = '{
    mk(0,0,0,0,0,IDL,1,0,8'h00, 0,0, 7), // R7 idle quiet
    mk(1,0,0,0,0,IDL,1,0,8'h00, 0,0, 1),
    mk(0,0,1,0,0,IDL,1,0,8'h54, 1,1, 1), // R1 write address match
    mk(0,0,0,1,0,SRX,1,0,8'h00, 0,1, 5), // R5 release
    mk(0,0,1,0,0,SRX,1,0,8'h12, 1,1, 3), // R3 slave data while addressed
    mk(0,0,0,1,0,SRX,1,0,8'h00, 0,1, 5),
    mk(0,1,0,0,0,SRX,1,0,8'h00, 0,0, 8), // R8 stop
    mk(1,0,0,0,0,IDL,1,0,8'h00, 0,0, 1),
    mk(0,0,1,0,0,IDL,1,0,8'h55, 1,1, 1), // R1 read bit ignored
    mk(0,0,0,1,0,SRX,1,0,8'h00, 0,1, 5),
    mk(1,0,0,0,0,SRX,1,0,8'h00, 0,1, 8), // R8 repeated start keeps flag
    mk(0,0,1,0,0,IDL,1,0,8'h30, 0,0, 8), // R8 mismatch after restart
    mk(1,0,0,0,0,IDL,1,0,8'h00, 0,0, 2),
    mk(0,0,1,0,0,IDL,1,0,8'h00, 0,0, 2), // R2 general call disabled
    mk(1,0,0,0,0,IDL,1,1,8'h00, 0,0, 2),
    mk(0,0,1,0,0,IDL,1,1,8'h00, 1,1, 2), // R2 general call accepted
    mk(0,0,0,1,0,SRX,1,1,8'h00, 0,1, 5),
    mk(0,0,1,0,0,SRX,0,1,8'h77, 0,1, 4), // R4 data not acked when off
    mk(0,1,0,0,0,SRX,0,1,8'h00, 0,0, 8),
    mk(1,0,0,0,0,IDL,0,0,8'h00, 0,0, 4),
    mk(0,0,1,0,0,IDL,0,0,8'h54, 0,0, 4), // R4 detached
    mk(1,0,0,0,0,IDL,1,0,8'h00, 0,0, 4),
    mk(0,0,1,0,0,IDL,1,0,8'h54, 1,1, 4), // R4 resumed
    mk(0,0,0,0,1,SRX,1,0,8'h00, 0,0, 6), // R6 recover in slave mode
    mk(0,0,1,0,0,SRX,1,0,8'h21, 0,0, 3), // R3 slave data unaddressed
    mk(0,0,1,0,0,MRX,1,0,8'h22, 1,0, 3), // R3 master receiver data
    mk(0,0,0,1,0,MRX,1,0,8'h00, 0,0, 5),
    mk(1,0,0,0,0,MRX,1,0,8'h00, 0,0, 9),
    mk(0,0,1,0,0,MRX,1,0,8'h54, 0,0, 9), // R9 own address as master
    mk(0,0,1,0,0,MRX,1,0,8'h23, 1,0, 3),
    mk(0,0,0,0,1,MRX,1,0,8'h00, 1,0, 6), // R6 ignored in master receiver
    mk(0,0,0,1,0,MRX,1,0,8'h00, 0,0, 5),
    mk(0,0,1,0,0,IDL,1,0,8'h24, 0,0, 9), // R9 idle data not acked
    mk(0,0,1,1,0,MRX,1,0,8'h25, 1,0, 5), // R5 byte_done wins over scl_fall
    mk(0,0,0,1,0,MRX,1,0,8'h00, 0,0, 5)
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b1;
  logic       ack_en = 1'b1;
  logic       gc_en = 1'b0;
  logic [6:0] own_addr = 7'h2A;
  logic [1:0] mode = IDL;
  logic       start_det = 1'b0;
  logic       stop_det = 1'b0;
  logic       byte_done = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       scl_fall = 1'b0;
  logic       recover = 1'b0;
  logic       sda_low;
  logic       addressed;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  i2cack_top uut (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .ack_en    (ack_en),
    .gc_en     (gc_en),
    .own_addr  (own_addr),
    .mode      (mode),
    .start_det (start_det),
    .stop_det  (stop_det),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .scl_fall  (scl_fall),
    .recover   (recover),
    .sda_low   (sda_low),
    .addressed (addressed)
  );

  task automatic check(input logic es, input logic ea, input int rq, input int idx);
    n_chk++;
    if (sda_low !== es || addressed !== ea) begin
      n_bad++;
      $display("FAIL R%0d step %0d: sda_low=%b addressed=%b expected %b %b",
               rq, idx, sda_low, addressed, es, ea);
    end
  endtask

  task automatic apply(input vec_t v, input int idx);
    start_det = v.st; stop_det = v.sp; byte_done = v.bd; scl_fall = v.fl;
    recover = v.rc; mode = v.md; ack_en = v.ae; gc_en = v.ge; rx_byte = v.b;
    @(negedge clk);
    start_det = 0; stop_det = 0; byte_done = 0; scl_fall = 0; recover = 0;
    check(v.es, v.ea, int'(v.rq), idx);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(1'b0, 1'b0, 7, -1); // R7 reset state
    for (int i = 0; i < NV; i++) apply(VECS[i], i);

    // R7: disable aborts a selected transfer and ignores bytes
    apply(mk(1,0,0,0,0,IDL,1,0,8'h00, 0,0, 7), 100);
    apply(mk(0,0,1,0,0,IDL,1,0,8'h54, 1,1, 7), 101);
    enable = 1'b0;
    apply(mk(0,0,0,0,0,SRX,1,0,8'h00, 0,0, 7), 102);
    apply(mk(1,0,0,0,0,IDL,1,0,8'h00, 0,0, 7), 103);
    apply(mk(0,0,1,0,0,IDL,1,0,8'h54, 0,0, 7), 104);
    enable = 1'b1;
    apply(mk(1,0,0,0,0,IDL,1,0,8'h00, 0,0, 7), 105);
    apply(mk(0,0,1,0,0,IDL,1,0,8'h55, 1,1, 7), 106);
    // R7: synchronous reset clears a live selection
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(1'b0, 1'b0, 7, 107);
    // R1: a different own address is honoured
    own_addr = 7'h7F;
    apply(mk(1,0,0,0,0,IDL,1,0,8'h00, 0,0, 1), 108);
    apply(mk(0,0,1,0,0,UNA,1,0,8'hFE, 1,1, 1), 109);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R7 watchdog: run did not finish, actual hung expected done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule